// File: doc/BRIEF.md
# Stream Core Run Control and End-of-Frame Tracker

This block sequences a streaming data-processing core between four operating states and keeps per-frame end-of-frame bookkeeping. Register-level controls (enable, pause, halt, and a halt-mode select) drive a small state machine. The state machine reports its state as four one-hot status flags: idle, run, wait and pause. When halt is requested, the core either drains its pending write-back before it stops or drops the write-back and stops at once.

Alongside the state machine, the block counts bytes on one side of the core. A select input picks the read (input) side or the write (output) side. When an end-of-frame event arrives on that side, the byte count of the frame is captured. If an earlier capture has not yet been acknowledged, the new event is flagged as lost. A write-one-to-clear trace strobe acknowledges the capture. After each end-of-frame, a tail phase stays active while a programmable number of extra data bits is still to pass.

Top module: `stream_runctl`

## Requirements
- R1: After reset, the idle flag is 1, the run, wait and pause flags are 0, the captured count is 0, the overload flag is 0 and the tail flag is 0.
- R2: Exactly one of the four status flags is 1 in every cycle.
- R3: From idle, the core moves to run in the next cycle when enable is 1 and halt is 0. Otherwise it stays idle.
- R4: With halt_mode 0, halt in run or pause moves the core to wait. It stays in wait until wb_done is 1 or halt_mode becomes 1, and then it goes to idle.
- R5: With halt_mode 1, halt in run or pause moves the core straight to idle in the next cycle. Halt takes priority over pause and enable.
- R6: In run, pause=1 (with halt 0 and enable 1) moves the core to pause, where byte counting stops. In pause, pause=0 with enable=1 returns the core to run. Enable=0 in run or pause goes to idle.
- R7: Bytes are counted one per strobe only while in run. eof_sel=0 uses rd_byte_stb and rd_eof, and eof_sel=1 uses wr_byte_stb and wr_eof. The other side's strobes and events are ignored. The count is cleared while idle and wraps at 14 bits.
- R8: On a selected EOF with no capture held, eof_cnt takes the frame's byte count in the next cycle. This count includes a strobe in the EOF cycle, and it is 0 if the core is idle. The frame count then restarts at 0.
- R9: A selected EOF that arrives while a capture is held sets eof_overload and leaves eof_cnt unchanged.
- R10: trace_clr clears eof_cnt, eof_overload and the held capture. If an EOF occurs in the same cycle, the new count is captured and the overload flag is cleared.
- R11: Each selected EOF loads tail_bits as the remaining bit count. Each counted byte strobe after that subtracts 8, with a floor of 0. tail_active is 1 while the remainder is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Core enable |
| pause | input | 1 | Pause request |
| halt | input | 1 | Halt request |
| halt_mode | input | 1 | 0: wait for write-back, 1: abandon it |
| wb_done | input | 1 | Write-back finished |
| eof_sel | input | 1 | 0: read side counted, 1: write side counted |
| tail_bits | input | 16 | Extra bits after EOF |
| rd_byte_stb | input | 1 | One byte read on input side |
| wr_byte_stb | input | 1 | One byte written on output side |
| rd_eof | input | 1 | EOF seen on input side |
| wr_eof | input | 1 | EOF seen on output side |
| trace_clr | input | 1 | Write-one clear of capture and overload |
| st_idle | output | 1 | Idle (halted) status |
| st_run | output | 1 | Run status |
| st_wait | output | 1 | Waiting for write-back |
| st_pause | output | 1 | Paused status |
| eof_cnt | output | 14 | Captured byte count |
| eof_overload | output | 1 | One or more EOFs lost |
| tail_active | output | 1 | Tail bits still pending |

## Verification
The bench targets several corner cases, and each one shows how a faulty design would fail. If halt arrives while paused, a design that lets pause win would stay paused. If the write-back wait ignores a late switch of halt_mode, the core would hang in wait. If an EOF and trace_clr land in the same cycle, a design that gives the clear priority would lose the new count. A lost EOF that overwrites the held count would hide the first frame's length. The bench also checks that strobes on the side that is not selected, and strobes while paused, leave the count alone. It checks that the tail remainder saturates at zero instead of wrapping.

// File: rtl/strc_pkg.sv
package strc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_PAUSE = 2'd3
  } run_state_e;

  // Next run-control state from the current state and the controls.
  function automatic run_state_e step_state(
    input run_state_e cur,
    input logic       en,
    input logic       pz,
    input logic       hlt,
    input logic       abandon,
    input logic       done
  );
    run_state_e nxt;
    nxt = cur;
    unique case (cur)
      ST_IDLE:  if (en && !hlt) nxt = ST_RUN;
      ST_RUN: begin
        if (hlt)       nxt = abandon ? ST_IDLE : ST_WAIT;
        else if (!en)  nxt = ST_IDLE;
        else if (pz)   nxt = ST_PAUSE;
      end
      ST_PAUSE: begin
        if (hlt)       nxt = abandon ? ST_IDLE : ST_WAIT;
        else if (!en)  nxt = ST_IDLE;
        else if (!pz)  nxt = ST_RUN;
      end
      ST_WAIT:  if (done || abandon) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

  // Remaining tail bits after one byte has passed, floor at zero.
  function automatic int unsigned tail_left(input int unsigned rem,
                                            input int unsigned per_byte);
    return (rem > per_byte) ? rem - per_byte : 0;
  endfunction

endpackage

// File: rtl/strc_fsm.sv
module strc_fsm
  import strc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       pause,
  input  logic       halt,
  input  logic       halt_mode,
  input  logic       wb_done,
  output run_state_e state_q,
  output logic       st_idle,
  output logic       st_run,
  output logic       st_wait,
  output logic       st_pause
);

  run_state_e state_n;

  always_comb state_n = step_state(state_q, enable, pause, halt, halt_mode, wb_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

  assign st_idle  = (state_q == ST_IDLE);
  assign st_run   = (state_q == ST_RUN);
  assign st_wait  = (state_q == ST_WAIT);
  assign st_pause = (state_q == ST_PAUSE);

  logic active;
  assign active = st_run || st_pause;

  // R2
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({st_idle, st_run, st_wait, st_pause}));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle && !(enable && !halt) |=> st_idle);

  // R3
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle && enable && !halt |=> st_run);

  // R4
  halt_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && halt && !halt_mode |=> st_wait);

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_wait && !wb_done && !halt_mode |=> st_wait);

  // R5
  halt_abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && halt && halt_mode |=> st_idle);

  // R6
  pause_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_run && enable && pause && !halt |=> st_pause);

endmodule

// File: rtl/strc_byte_track.sv
module strc_byte_track #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eof_sel,
  input  logic             rd_byte_stb,
  input  logic             wr_byte_stb,
  input  logic             rd_eof,
  input  logic             wr_eof,
  input  logic             in_run,
  input  logic             in_idle,
  output logic             byte_stb,
  output logic             eof_ev,
  output logic [CNT_W-1:0] frame_bytes
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_sum;
  logic             sel_stb;

  assign sel_stb  = eof_sel ? wr_byte_stb : rd_byte_stb;
  assign eof_ev   = eof_sel ? wr_eof : rd_eof;
  assign byte_stb = sel_stb && in_run;
  assign cnt_sum  = cnt_q + CNT_W'(byte_stb);

  assign frame_bytes = in_idle ? '0 : cnt_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (in_idle || eof_ev) cnt_q <= '0;
    else                        cnt_q <= cnt_sum;
  end

  // R7
  count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_run |=> (cnt_q == '0) || $stable(cnt_q));

endmodule

// File: rtl/strc_eof_trace.sv
module strc_eof_trace #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eof_ev,
  input  logic             trace_clr,
  input  logic [CNT_W-1:0] frame_bytes,
  output logic [CNT_W-1:0] eof_cnt,
  output logic             eof_overload,
  output logic             cap_take,
  output logic             eof_lost
);

  logic held_q;

  assign cap_take = eof_ev && (trace_clr || !held_q);
  assign eof_lost = eof_ev && held_q && !trace_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eof_cnt      <= '0;
      eof_overload <= 1'b0;
      held_q       <= 1'b0;
    end else if (cap_take) begin
      eof_cnt <= frame_bytes;
      held_q  <= 1'b1;
      if (trace_clr) eof_overload <= 1'b0;
    end else if (eof_lost) begin
      eof_overload <= 1'b1;
    end else if (trace_clr) begin
      eof_cnt      <= '0;
      eof_overload <= 1'b0;
      held_q       <= 1'b0;
    end
  end

  // R8
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_take |=> eof_cnt == $past(frame_bytes));

  // R9
  lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_lost |=> eof_overload && $stable(eof_cnt));

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trace_clr && !eof_ev |=> !eof_overload && (eof_cnt == '0));

endmodule

// File: rtl/strc_tail.sv
module strc_tail
  import strc_pkg::*;
#(
  parameter int TAIL_W   = 16,
  parameter int PER_BYTE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eof_ev,
  input  logic              byte_stb,
  input  logic [TAIL_W-1:0] tail_bits,
  output logic              tail_active
);

  logic [TAIL_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rem_q <= '0;
    else if (eof_ev)
      rem_q <= tail_bits;
    else if (byte_stb && rem_q != '0)
      rem_q <= TAIL_W'(tail_left(32'(rem_q), PER_BYTE));
  end

  assign tail_active = (rem_q != '0);

  // R11
  tail_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_ev |=> tail_active == ($past(tail_bits) != '0));

endmodule

// File: rtl/stream_runctl.sv
module stream_runctl
  import strc_pkg::*;
#(
  parameter int CNT_W    = 14,
  parameter int TAIL_W   = 16,
  parameter int PER_BYTE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              pause,
  input  logic              halt,
  input  logic              halt_mode,
  input  logic              wb_done,
  input  logic              eof_sel,
  input  logic [TAIL_W-1:0] tail_bits,
  input  logic              rd_byte_stb,
  input  logic              wr_byte_stb,
  input  logic              rd_eof,
  input  logic              wr_eof,
  input  logic              trace_clr,
  output logic              st_idle,
  output logic              st_run,
  output logic              st_wait,
  output logic              st_pause,
  output logic [CNT_W-1:0]  eof_cnt,
  output logic              eof_overload,
  output logic              tail_active
);

  run_state_e       state_q;
  logic             byte_stb;
  logic             eof_ev;
  logic [CNT_W-1:0] frame_bytes;
  logic             cap_take;
  logic             eof_lost;

  strc_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .pause     (pause),
    .halt      (halt),
    .halt_mode (halt_mode),
    .wb_done   (wb_done),
    .state_q   (state_q),
    .st_idle   (st_idle),
    .st_run    (st_run),
    .st_wait   (st_wait),
    .st_pause  (st_pause)
  );

  strc_byte_track #(.CNT_W(CNT_W)) u_bytes (
    .clk         (clk),
    .rst_n       (rst_n),
    .eof_sel     (eof_sel),
    .rd_byte_stb (rd_byte_stb),
    .wr_byte_stb (wr_byte_stb),
    .rd_eof      (rd_eof),
    .wr_eof      (wr_eof),
    .in_run      (state_q == ST_RUN),
    .in_idle     (state_q == ST_IDLE),
    .byte_stb    (byte_stb),
    .eof_ev      (eof_ev),
    .frame_bytes (frame_bytes)
  );

  strc_eof_trace #(.CNT_W(CNT_W)) u_trace (
    .clk          (clk),
    .rst_n        (rst_n),
    .eof_ev       (eof_ev),
    .trace_clr    (trace_clr),
    .frame_bytes  (frame_bytes),
    .eof_cnt      (eof_cnt),
    .eof_overload (eof_overload),
    .cap_take     (cap_take),
    .eof_lost     (eof_lost)
  );

  strc_tail #(.TAIL_W(TAIL_W), .PER_BYTE(PER_BYTE)) u_tail (
    .clk         (clk),
    .rst_n       (rst_n),
    .eof_ev      (eof_ev),
    .byte_stb    (byte_stb),
    .tail_bits   (tail_bits),
    .tail_active (tail_active)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> st_idle && !eof_overload && !tail_active);

  // R8
  take_or_lose_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_ev |-> (cap_take != eof_lost));

endmodule

// File: tb/stream_runctl_test.sv
`timescale 1ns/100ps
module stream_runctl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 0, pause = 0, halt = 1, halt_mode = 0, wb_done = 0;
  logic        eof_sel = 0;
  logic [15:0] tail_bits = 0;
  logic        rd_byte_stb = 0, wr_byte_stb = 0, rd_eof = 0, wr_eof = 0;
  logic        trace_clr = 0;
  logic        st_idle, st_run, st_wait, st_pause;
  logic [13:0] eof_cnt;
  logic        eof_overload, tail_active;

  always #2.5 clk = ~clk;

  stream_runctl uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pause(pause), .halt(halt),
    .halt_mode(halt_mode), .wb_done(wb_done), .eof_sel(eof_sel),
    .tail_bits(tail_bits), .rd_byte_stb(rd_byte_stb), .wr_byte_stb(wr_byte_stb),
    .rd_eof(rd_eof), .wr_eof(wr_eof), .trace_clr(trace_clr),
    .st_idle(st_idle), .st_run(st_run), .st_wait(st_wait), .st_pause(st_pause),
    .eof_cnt(eof_cnt), .eof_overload(eof_overload), .tail_active(tail_active)
  );

  int errors = 0;
  int checks = 0;

  // Reference model: 0 idle, 1 run, 2 wait, 3 pause
  int m_st, m_cnt, m_cap, m_rem;
  bit m_held, m_ovl;

  task automatic model_step();
    int nst, sum, cap;
    bit stb, ev;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_cap = 0; m_rem = 0; m_held = 0; m_ovl = 0;
      return;
    end
    stb = (eof_sel ? wr_byte_stb : rd_byte_stb) && (m_st == 1);
    ev  = eof_sel ? wr_eof : rd_eof;
    sum = (m_cnt + (stb ? 1 : 0)) % 16384;
    cap = (m_st == 0) ? 0 : sum;
    nst = m_st;
    if (m_st == 0) begin
      if (enable && !halt) nst = 1;
    end else if (m_st == 2) begin
      if (wb_done || halt_mode) nst = 0;
    end else begin
      if (halt) nst = halt_mode ? 0 : 2;
      else if (!enable) nst = 0;
      else if (m_st == 1 && pause) nst = 3;
      else if (m_st == 3 && !pause) nst = 1;
    end
    if (ev && (trace_clr || !m_held)) begin
      m_cap = cap; m_held = 1;
      if (trace_clr) m_ovl = 0;
    end else if (ev) begin
      m_ovl = 1;
    end else if (trace_clr) begin
      m_cap = 0; m_ovl = 0; m_held = 0;
    end
    if (ev) m_rem = tail_bits;
    else if (stb && m_rem != 0) m_rem = (m_rem > 8) ? m_rem - 8 : 0;
    m_cnt = (m_st == 0 || ev) ? 0 : sum;
    m_st = nst;
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    bit rnd;
    int exp_flags;
    rnd = (tag == "rnd");
    exp_flags = 1 << m_st;
    check(rnd ? "R2" : tag, "flags", {st_pause, st_wait, st_run, st_idle}, exp_flags);
    check(rnd ? "R8" : tag, "eof_cnt", eof_cnt, m_cap);
    check(rnd ? "R9" : tag, "overload", eof_overload, m_ovl);
    check(rnd ? "R11" : tag, "tail", tail_active, m_rem != 0);
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    #1;
    compare(tag);
  endtask

  task automatic idle_ins();
    rd_byte_stb = 0; wr_byte_stb = 0; rd_eof = 0; wr_eof = 0; trace_clr = 0; wb_done = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_step();
    repeat (3) cyc("R1");
    #0 rst_n = 1;
    cyc("R1");
    // R3: enable with halt set keeps idle
    enable = 1; halt = 1;
    cyc("R3"); cyc("R3");
    halt = 0;
    cyc("R3");
    // R7: count read side, write side ignored
    for (int i = 0; i < 5; i++) begin rd_byte_stb = 1; wr_byte_stb = (i % 2 == 0); cyc("R7"); end
    idle_ins();
    // R8 + R11: EOF with a strobe, tail 20 bits
    tail_bits = 16'd20; rd_eof = 1; rd_byte_stb = 1;
    cyc("R8");
    rd_eof = 0;
    for (int i = 0; i < 4; i++) cyc("R11");
    idle_ins(); cyc("R11");
    // R9: lost EOF while capture held
    rd_byte_stb = 1; cyc("R9"); idle_ins();
    wr_eof = 1; cyc("R7"); idle_ins();
    rd_eof = 1; cyc("R9"); idle_ins(); cyc("R9");
    // R10: clear, then clear together with EOF
    trace_clr = 1; cyc("R10"); idle_ins(); cyc("R10");
    rd_eof = 1; cyc("R10"); idle_ins();
    rd_eof = 1; cyc("R9"); idle_ins();
    rd_byte_stb = 1; rd_eof = 1; trace_clr = 1; cyc("R10"); idle_ins(); cyc("R10");
    // R6: pause freezes counting
    pause = 1; rd_byte_stb = 1; cyc("R6"); cyc("R6"); cyc("R6");
    pause = 0; cyc("R6"); cyc("R6"); idle_ins();
    trace_clr = 1; rd_eof = 1; cyc("R6"); idle_ins();
    // R5: halt while paused with abandon
    pause = 1; cyc("R6");
    halt = 1; halt_mode = 1; cyc("R5"); cyc("R5");
    halt = 0; halt_mode = 0; cyc("R3");
    // R4: halt waits for write-back
    halt = 1; cyc("R4"); cyc("R4"); cyc("R4");
    wb_done = 1; cyc("R4"); wb_done = 0;
    halt = 0; pause = 0; cyc("R3");
    halt = 1; cyc("R4"); halt_mode = 1; cyc("R4"); halt_mode = 0; halt = 0;
    cyc("R3");
    // R7: write side selected, read side ignored
    eof_sel = 1; trace_clr = 1; cyc("R10"); idle_ins();
    for (int i = 0; i < 6; i++) begin wr_byte_stb = 1; rd_byte_stb = 1; rd_eof = (i == 2); cyc("R7"); end
    idle_ins(); wr_eof = 1; tail_bits = 16'd3; cyc("R7"); idle_ins();
    wr_byte_stb = 1; cyc("R11"); idle_ins(); cyc("R11");
    // R6: enable drop goes idle, EOF in idle captures 0
    enable = 0; cyc("R6");
    trace_clr = 1; wr_eof = 1; cyc("R8"); idle_ins(); cyc("R8");
    // Random mixed traffic
    for (int i = 0; i < 5000; i++) begin
      enable      = ($urandom % 20) != 0;
      if ($urandom % 12 == 0) halt = ~halt;
      if ($urandom % 10 == 0) pause = ~pause;
      if ($urandom % 40 == 0) halt_mode = ~halt_mode;
      if ($urandom % 200 == 0) eof_sel = ~eof_sel;
      wb_done     = ($urandom % 4) == 0;
      rd_byte_stb = $urandom % 2;
      wr_byte_stb = $urandom % 2;
      rd_eof      = ($urandom % 25) == 0;
      wr_eof      = ($urandom % 25) == 0;
      trace_clr   = ($urandom % 20) == 0;
      tail_bits   = 16'($urandom % 64);
      cyc("rnd");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule